// File: doc/BRIEF.md
# Double-Buffered Serial Code Register Front End

This block is the digital input side of a 12-bit voltage-output converter. A host writes a code over a three-wire serial port: a data line, a serial clock and an active-low select. Bits go into a shift register, most significant bit first. A second register, the holding register, drives the parallel code that the converter would turn into a voltage. The code is natural binary. Because the two registers are separate, the host can preload the next code while the output keeps the present one.

The holding register responds to two control pins. An active-low load strobe makes it transparent while the strobe is low, and the register captures the shift register when the strobe returns high. An active-low clear forces the output code to zero at once, with no clock needed, and it wins over the load strobe. All pins are sampled by a fast system clock through two-flop synchronizers, and edges are found by comparing successive samples. Each serial clock phase and each control pulse must therefore last at least three system clock cycles. A status flag reports that the serial clock was driven while the load strobe was low, which the host must not do.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the output code is 0, and the transparent flag and the misuse flag are both 0.
- R2: With select low, each rising serial clock edge shifts one data bit into bit 0 and moves the earlier bits up one place. A 12-bit transfer leaves the first bit sent in bit 11 of the code.
- R3: While select stays high, serial clock edges and data changes leave the shift register unchanged.
- R4: A rising edge on select while the serial clock is high shifts one bit, exactly like a serial clock edge. A falling select while the clock is high shifts nothing.
- R5: When more than 12 bits are shifted in, only the last 12 are kept. A 16-bit transfer of 0xABCD leaves 0xBCD.
- R6: While load is low and clear is high, the output code follows the shift register and the transparent flag is 1.
- R7: The rising edge of load captures the shift register. Later shifting with load high does not change the output code.
- R8: While clear is low, the output code is 0. This holds in the same instant clear falls, before any clock edge, and whatever the load strobe does.
- R9: If clear is released while load is high, the output code stays 0 until the next load.
- R10: A shift that happens while load is low sets the misuse flag. The flag stays set until load is seen high again.
- R11: Clear takes priority over load. With both low, the code is 0 and the transparent flag is 0. When clear is released with load still low, the code follows the shift register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| sel_n_i | input | 1 | Active-low serial select |
| load_n_i | input | 1 | Active-low load strobe for the holding register |
| clear_n_i | input | 1 | Active-low clear of the holding register |
| code_o | output | 12 | Held converter code, natural binary |
| transparent_o | output | 1 | High while the holding register follows the shift register |
| misuse_o | output | 1 | Set when a shift is seen while load is low |

## Verification
The main path is driven with all-zero and all-one codes, a walking one, a walking zero and a stride sweep. Together these tell apart a reversed bit order, stuck bits and bits swapped between neighbours, and each code is checked only after a load strobe. Before every load the output is compared with the previous code, which shows whether preloading disturbs the held value. Separate patterns cover the rest:
- a 16-bit overflow transfer, which shows whether extra bits are dropped from the top;
- serial clock toggling with select high, which should shift nothing;
- a select rise with the clock held high, which should shift exactly one bit;
- clear asserted with load both high and low, with the output sampled before any clock edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned PIN_N   = 5;
  localparam int unsigned PIN_DIN = 0;
  localparam int unsigned PIN_SCK = 1;
  localparam int unsigned PIN_SEL = 2;
  localparam int unsigned PIN_LD  = 3;
  localparam int unsigned PIN_CLR = 4;
  // idle levels: clear, load, select high; clock and data low
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11100;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned CODE_W = sdac_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_s,
  input  logic              sck_s,
  input  logic              sel_s,
  output logic [CODE_W-1:0] shreg_o,
  output logic              shift_o
);
  logic              sck_q, sel_q;
  logic [CODE_W-1:0] shreg_q, shreg_d;
  logic              sck_rise, sel_rise, shift;

  always_comb begin
    sck_rise = sck_s & ~sck_q;
    sel_rise = sel_s & ~sel_q;
    shift    = (sck_rise & ~sel_s) | (sel_rise & sck_s);
    shreg_d  = {shreg_q[CODE_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg_q <= '0;
    else if (shift) shreg_q <= shreg_d;
  end

  assign shreg_o = shreg_q;
  assign shift_o = shift;

  AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && sel_q) |=> shreg_q == $past(shreg_q)); // R3
  AST_SHIFT_LSB_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> shreg_q[0] == $past(din_s)); // R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> shreg_q[CODE_W-1:1] == $past(shreg_q[CODE_W-2:0])); // R5
  AST_SEL_RISE_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && !sel_q && sck_s) |-> shift); // R4
endmodule

// File: rtl/sdac_holdreg.sv
module sdac_holdreg #(
  parameter int unsigned CODE_W = sdac_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_s,
  input  logic              ld_s,
  input  logic [CODE_W-1:0] shreg_i,
  output logic [CODE_W-1:0] hold_o
);
  logic              ld_q;
  logic [CODE_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    hold_en = ~clr_s | ~ld_s | (ld_s & ~ld_q);
    hold_d  = clr_s ? shreg_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= 1'b1;
    else        ld_q <= ld_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> hold_q == '0); // R8
  AST_TRANSPARENT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && !ld_s) |=> hold_q == $past(shreg_i)); // R6
  AST_LATCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && ld_s && ld_q) |=> hold_q == $past(hold_q)); // R7
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter int unsigned CODE_W = sdac_pkg::CODE_W,
  parameter int unsigned SYNC_N = sdac_pkg::SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              sel_n_i,
  input  logic              load_n_i,
  input  logic              clear_n_i,
  output logic [CODE_W-1:0] code_o,
  output logic              transparent_o,
  output logic              misuse_o
);
  import sdac_pkg::*;

  logic              rst_meta_q, rst_q;
  logic [PIN_N-1:0]  pins_raw, pins_s;
  logic [CODE_W-1:0] shreg, hold;
  logic              shift;
  logic              transp_q, transp_d;
  logic              misuse_q, misuse_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  always_comb begin
    pins_raw          = '0;
    pins_raw[PIN_DIN] = ser_data_i;
    pins_raw[PIN_SCK] = ser_clk_i;
    pins_raw[PIN_SEL] = sel_n_i;
    pins_raw[PIN_LD]  = load_n_i;
    pins_raw[PIN_CLR] = clear_n_i;
  end

  sdac_sync #(.W(PIN_N), .STAGES(SYNC_N), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  sdac_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_q),
    .din_s   (pins_s[PIN_DIN]),
    .sck_s   (pins_s[PIN_SCK]),
    .sel_s   (pins_s[PIN_SEL]),
    .shreg_o (shreg),
    .shift_o (shift)
  );

  sdac_holdreg #(.CODE_W(CODE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr_s   (pins_s[PIN_CLR]),
    .ld_s    (pins_s[PIN_LD]),
    .shreg_i (shreg),
    .hold_o  (hold)
  );

  always_comb begin
    transp_d = pins_s[PIN_CLR] & ~pins_s[PIN_LD];
    misuse_d = ~pins_s[PIN_LD] & (misuse_q | shift);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      transp_q <= 1'b0;
      misuse_q <= 1'b0;
    end else begin
      transp_q <= transp_d;
      misuse_q <= misuse_d;
    end
  end

  // clear reaches the output without waiting for a clock
  assign code_o        = clear_n_i ? hold : '0;
  assign transparent_o = transp_q;
  assign misuse_o      = misuse_q;

  AST_CLEAR_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_q)
    !pins_s[PIN_CLR] |=> !transparent_o); // R11
  AST_MISUSE_SET: assert property (@(posedge clk) disable iff (!rst_q)
    (shift && !pins_s[PIN_LD]) |=> misuse_o); // R10
  AST_MISUSE_DROP: assert property (@(posedge clk) disable iff (!rst_q)
    pins_s[PIN_LD] |=> !misuse_o); // R10
endmodule

// File: tb/sdac_frontend_tb_top.sv
`timescale 1ns/1ps
module sdac_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        din, sck, sel_n, ld_n, clr_n;
  logic [11:0] code;
  logic        transp, misuse;
  logic [11:0] model;
  logic [11:0] held;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  sdac_frontend dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_data_i    (din),
    .ser_clk_i     (sck),
    .sel_n_i       (sel_n),
    .load_n_i      (ld_n),
    .clear_n_i     (clr_n),
    .code_o        (code),
    .transparent_o (transp),
    .misuse_o      (misuse)
  );

  task automatic gap();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] val, input int n);
    sel_n = 1'b0; gap();
    for (int i = n - 1; i >= 0; i--) begin
      din = val[i]; gap();
      sck = 1'b1;  gap();
      sck = 1'b0;  gap();
      model = {model[10:0], val[i]};
    end
    sel_n = 1'b1; gap();
  endtask

  task automatic pulse_load();
    ld_n = 1'b0; gap();
    ld_n = 1'b1; gap();
    held = model;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] words [$];
    rst_n = 1'b0; din = 1'b0; sck = 1'b0; sel_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
    model = '0; held = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    gap();
    // R1 reset state
    chk("R1 code", code, 12'h000);
    chk("R1 transparent", {11'd0, transp}, 12'd0);
    chk("R1 misuse", {11'd0, misuse}, 12'd0);

    // R2 / R7 sweep of codes, double buffering checked before each load
    words.push_back(12'h000); words.push_back(12'hFFF);
    for (int b = 0; b < 12; b++) words.push_back(12'h001 << b);
    for (int b = 0; b < 12; b++) words.push_back(~(12'h001 << b));
    for (int k = 0; k < 16; k++) words.push_back(12'((k * 397 + 5) % 4096));
    foreach (words[w]) begin
      shift_bits({20'd0, words[w]}, 12);
      chk("R7 preload keeps code", code, held);
      pulse_load();
      chk("R2 loaded code", code, words[w]);
    end

    // R3 clock activity while deselected
    for (int k = 0; k < 5; k++) begin
      din = k[0]; gap(); sck = 1'b1; gap(); sck = 1'b0; gap();
    end
    pulse_load();
    chk("R3 deselected clocks ignored", code, model);

    // R4 select rise with clock high shifts one bit
    sck = 1'b1; gap();
    din = 1'b1; sel_n = 1'b0; gap();
    sel_n = 1'b1; gap();
    sck = 1'b0; gap();
    model = {model[10:0], 1'b1};
    pulse_load();
    chk("R4 select edge shift", code, model);

    // R5 overflow transfer
    shift_bits(32'h0000ABCD, 16);
    pulse_load();
    chk("R5 last twelve kept", code, 12'hBCD);

    // R6 / R10 transparency and misuse
    ld_n = 1'b0; gap();
    chk("R6 transparent flag", {11'd0, transp}, 12'd1);
    chk("R6 follows shift reg", code, model);
    chk("R10 no misuse without shift", {11'd0, misuse}, 12'd0);
    sel_n = 1'b0; gap();
    for (int k = 0; k < 3; k++) begin
      din = ~k[0]; gap(); sck = 1'b1; gap(); sck = 1'b0; gap();
      model = {model[10:0], ~k[0]};
      chk("R6 follows while shifting", code, model);
      chk("R10 misuse set", {11'd0, misuse}, 12'd1);
    end
    sel_n = 1'b1; gap();
    ld_n = 1'b1; gap();
    held = model;
    chk("R10 misuse cleared", {11'd0, misuse}, 12'd0);
    chk("R6 transparent flag low", {11'd0, transp}, 12'd0);
    chk("R7 latched on rise", code, held);
    shift_bits(32'h00000A5A, 12);
    chk("R7 shift after latch", code, held);

    // R8 clockless clear, then R9 release with load high
    @(negedge clk); clr_n = 1'b0; #1;
    chk("R8 immediate zero", code, 12'h000);
    gap();
    ld_n = 1'b0; gap();
    chk("R8 zero with load low", code, 12'h000);
    chk("R11 no transparency in clear", {11'd0, transp}, 12'd0);
    ld_n = 1'b1; gap();
    clr_n = 1'b1; gap();
    chk("R9 zero after release", code, 12'h000);
    // R11 clear with load low, then release while load low
    ld_n = 1'b0; clr_n = 1'b0; gap();
    chk("R11 clear wins", code, 12'h000);
    clr_n = 1'b1; gap();
    chk("R11 follows after release", code, model);
    chk("R11 transparent after release", {11'd0, transp}, 12'd1);
    ld_n = 1'b1; gap();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule